// File: doc/BRIEF.md
# Load Color Squash Tracker

This block records, for every slot of an out-of-order scheduler, which loads still awaiting a hit/miss verdict the slot's contents depend on. The dependence may be direct or reached through any chain of producers. Each load in flight is given a color, which is one bit of a fixed-width vector. A dispatched instruction's vector is the OR of its producers' vectors. A load also adds its own freshly allocated bit. Because bits are only ever ORed forward, a grandchild carries the color of every load above it.

When the cache side reports a verdict for a color, the block removes that bit from every stored vector and returns the color to the free pool. A miss verdict also raises a one-cycle squash flag on every slot that held the bit, so only true descendants are replayed. A slot whose vector is empty depends on no unresolved load and may be freed by the scheduler.

Dispatch is a valid/ready stream. `disp_ready` depends only on `disp_is_load` and the pool state. It drops only for a load offered while every color is taken, and `color_stall` then reports the reason. A non-load is always accepted. While `disp_valid && !disp_ready`, nothing changes and the offer may be held or changed. Verdicts are plain single-cycle strobes with no back-pressure.

Top module: `load_color_tracker`

## Requirements
- R1: After reset all slot vectors are zero, all squash flags are low, every color is free, and `disp_ready` is high.
- R2: An accepted load is given the lowest-numbered free color. Color c is bit c of a vector, and `disp_color` shows its index in the same cycle. That bit is set in the load's stored vector after the clock edge.
- R3: A dispatched slot stores the OR of the vectors of its producers whose `disp_src_vld` bit is set. Producers whose valid bit is low contribute nothing.
- R4: A load that consumes another load's result stores both the parent's color bit and its own.
- R5: A miss verdict for color c raises `squash_mask[i]`, for one cycle after the edge, exactly for the slots whose vector held bit c. This includes transitive descendants.
- R6: Any verdict for color c clears bit c in every slot and frees c. The color can then be allocated from the following cycle on, and no free color is ever held by a slot.
- R7: With no free color, an offered load sees `disp_ready` low and `color_stall` high, and no state changes. A non-load is still accepted in that state.
- R8: If a miss for color c coincides with a dispatch whose producers carry c, the newly written slot is flagged for squash. Its stored vector does not keep bit c.
- R9: `retire_ok[i]` is high exactly when slot i's vector is zero.
- R10: A hit verdict raises no squash flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer valid |
| disp_ready | output | 1 | Dispatch accepted when high together with valid |
| disp_entry | input | EW | Scheduler slot being written |
| disp_is_load | input | 1 | Offered instruction is a load needing a color |
| disp_src_vld | input | NUM_SRC | Per-operand flag: operand comes from an in-flight producer |
| disp_src_entry | input | NUM_SRC*EW | Producer slot index per operand |
| disp_color | output | CW | Color given to the offered load |
| color_stall | output | 1 | Load offered while no color is free |
| res_valid | input | 1 | Verdict strobe |
| res_hit | input | 1 | 1 = hit, 0 = miss |
| res_color | input | CW | Color the verdict refers to |
| squash_mask | output | NUM_ENTRIES | One-cycle squash flags per slot |
| retire_ok | output | NUM_ENTRIES | Slot vector empty |
| ent_vec | output | NUM_ENTRIES*NUM_COLORS | All stored vectors, slot i at bits i*NUM_COLORS upward |

## Verification
The bench uses 8 slots, 4 colors and 2 operands per instruction. With only four colors, the pool runs dry often, so the stall path and the reuse of freed colors are exercised many times. With eight slots, random producer picks often form chains two or three loads deep. Random verdicts often land in the same cycle as dispatches that inherit the resolved color.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic {
    RES_MISS = 1'b0,
    RES_HIT  = 1'b1
  } lct_res_e;
endpackage

// File: rtl/lct_color_pool.sv
module lct_color_pool #(
  parameter int NUM_COLORS = 4,
  localparam int CW = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_fire,
  output logic                  any_free,
  output logic [CW-1:0]         alloc_idx,
  input  logic                  rel_valid,
  input  logic [CW-1:0]         rel_idx,
  output logic [NUM_COLORS-1:0] free_mask
);
  logic [NUM_COLORS-1:0] free_q, free_d;

  // lowest-numbered free color
  always_comb begin
    any_free  = 1'b0;
    alloc_idx = '0;
    for (int c = NUM_COLORS - 1; c >= 0; c--) begin
      if (free_q[c]) begin
        alloc_idx = CW'(c);
        any_free  = 1'b1;
      end
    end
  end

  always_comb begin
    free_d = free_q;
    if (alloc_fire) free_d[alloc_idx] = 1'b0;
    if (rel_valid)  free_d[rel_idx]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= free_d;
  end

  assign free_mask = free_q;

  AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !free_q[$past(alloc_idx)]); // R2
  AST_VERDICT_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> !free_q[rel_idx]); // R6
endmodule

// File: rtl/lct_parent_merge.sv
module lct_parent_merge #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_COLORS  = 4,
  parameter int NUM_SRC     = 2,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES*NUM_COLORS-1:0] vec_flat,
  input  logic [NUM_SRC-1:0]                src_vld,
  input  logic [NUM_SRC*EW-1:0]             src_entry,
  output logic [NUM_COLORS-1:0]             merged
);
  logic [NUM_COLORS-1:0] per_src [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      per_src[s] = '0;
      if (src_vld[s])
        per_src[s] = vec_flat[int'(src_entry[s*EW +: EW])*NUM_COLORS +: NUM_COLORS];
    end
  end

  always_comb begin
    merged = '0;
    for (int s = 0; s < NUM_SRC; s++) merged = merged | per_src[s];
  end
endmodule

// File: rtl/lct_vec_array.sv
module lct_vec_array #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_COLORS  = 4,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CW = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [EW-1:0]                     wr_idx,
  input  logic [NUM_COLORS-1:0]             wr_vec,
  input  logic                              clr_en,
  input  logic [CW-1:0]                     clr_idx,
  input  logic                              miss_en,
  output logic [NUM_ENTRIES*NUM_COLORS-1:0] vec_flat,
  output logic [NUM_ENTRIES-1:0]            squash,
  output logic [NUM_COLORS-1:0]             col_any
);
  logic [NUM_COLORS-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic [NUM_COLORS-1:0] vec_q;
    logic                  sq_q;
    logic                  sel;
    logic [NUM_COLORS-1:0] seen;

    assign sel  = wr_en && (wr_idx == EW'(e));
    assign seen = sel ? wr_vec : vec_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_q <= '0;
        sq_q  <= 1'b0;
      end else begin
        vec_q <= seen & ~clr_mask;
        sq_q  <= miss_en && ((seen & clr_mask) != '0);
      end
    end

    assign vec_flat[e*NUM_COLORS +: NUM_COLORS] = vec_q;
    assign squash[e] = sq_q;
  end

  always_comb begin
    col_any = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      col_any = col_any | vec_flat[e*NUM_COLORS +: NUM_COLORS];
  end

  AST_BIT_SWEPT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !col_any[$past(clr_idx)]); // R6
  AST_SQUASH_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (squash != '0) |-> $past(miss_en)); // R10
endmodule

// File: rtl/load_color_tracker.sv
module load_color_tracker
  import lct_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_COLORS  = 4,
  parameter int NUM_SRC     = 2,
  localparam int EW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CW = (NUM_COLORS > 1) ? $clog2(NUM_COLORS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              disp_valid,
  output logic                              disp_ready,
  input  logic [EW-1:0]                     disp_entry,
  input  logic                              disp_is_load,
  input  logic [NUM_SRC-1:0]                disp_src_vld,
  input  logic [NUM_SRC*EW-1:0]             disp_src_entry,
  output logic [CW-1:0]                     disp_color,
  output logic                              color_stall,
  input  logic                              res_valid,
  input  logic                              res_hit,
  input  logic [CW-1:0]                     res_color,
  output logic [NUM_ENTRIES-1:0]            squash_mask,
  output logic [NUM_ENTRIES-1:0]            retire_ok,
  output logic [NUM_ENTRIES*NUM_COLORS-1:0] ent_vec
);
  logic                  any_free;
  logic                  fire;
  logic                  load_fire;
  logic                  miss_en;
  logic [NUM_COLORS-1:0] free_mask;
  logic [NUM_COLORS-1:0] merged;
  logic [NUM_COLORS-1:0] own_vec;
  logic [NUM_COLORS-1:0] col_any;
  lct_res_e              res_kind;

  assign disp_ready  = !disp_is_load || any_free;
  assign color_stall = disp_valid && disp_is_load && !any_free;
  assign fire        = disp_valid && disp_ready;
  assign load_fire   = fire && disp_is_load;
  assign res_kind    = lct_res_e'(res_hit);
  assign miss_en     = res_valid && (res_kind == RES_MISS);

  lct_color_pool #(.NUM_COLORS(NUM_COLORS)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_fire(load_fire),
    .any_free  (any_free),
    .alloc_idx (disp_color),
    .rel_valid (res_valid),
    .rel_idx   (res_color),
    .free_mask (free_mask)
  );

  lct_parent_merge #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_COLORS(NUM_COLORS), .NUM_SRC(NUM_SRC)
  ) u_merge (
    .vec_flat (ent_vec),
    .src_vld  (disp_src_vld),
    .src_entry(disp_src_entry),
    .merged   (merged)
  );

  always_comb begin
    own_vec = '0;
    if (load_fire) own_vec[disp_color] = 1'b1;
  end

  lct_vec_array #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_COLORS(NUM_COLORS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire),
    .wr_idx  (disp_entry),
    .wr_vec  (merged | own_vec),
    .clr_en  (res_valid),
    .clr_idx (res_color),
    .miss_en (miss_en),
    .vec_flat(ent_vec),
    .squash  (squash_mask),
    .col_any (col_any)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ret
    assign retire_ok[e] = (ent_vec[e*NUM_COLORS +: NUM_COLORS] == '0);
  end

  AST_FREE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (free_mask & col_any) == '0); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    color_stall |-> !disp_ready); // R7
endmodule

// File: tb/load_color_tracker_tb.sv
module load_color_tracker_tb;
  localparam int NE = 8;
  localparam int NC = 4;
  localparam int NS = 2;
  localparam int EW = 3;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_is_load = 1'b0;
  logic [EW-1:0] disp_entry = '0;
  logic [NS-1:0] disp_src_vld = '0;
  logic [NS*EW-1:0] disp_src_entry = '0;
  logic res_valid = 1'b0, res_hit = 1'b0;
  logic [CW-1:0] res_color = '0;
  logic disp_ready, color_stall;
  logic [CW-1:0] disp_color;
  logic [NE-1:0] squash_mask, retire_ok;
  logic [NE*NC-1:0] ent_vec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NC-1:0] mv [NE];
  logic [NC-1:0] mfree;
  logic [NE-1:0] msq;

  always #5 clk = ~clk;

  load_color_tracker #(.NUM_ENTRIES(NE), .NUM_COLORS(NC), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_entry(disp_entry), .disp_is_load(disp_is_load), .disp_src_vld(disp_src_vld),
    .disp_src_entry(disp_src_entry), .disp_color(disp_color), .color_stall(color_stall),
    .res_valid(res_valid), .res_hit(res_hit), .res_color(res_color),
    .squash_mask(squash_mask), .retire_ok(retire_ok), .ent_vec(ent_vec)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lowest_free(input logic [NC-1:0] f);
    for (int c = 0; c < NC; c++) if (f[c]) return c;
    return -1;
  endfunction

  task automatic check_state(input string tag);
    logic [NE*NC-1:0] ev;
    logic [NE-1:0] er;
    for (int e = 0; e < NE; e++) begin
      ev[e*NC +: NC] = mv[e];
      er[e] = (mv[e] == '0);
    end
    chk(tag, "vectors", 64'(ent_vec), 64'(ev));
    chk(tag, "squash", 64'(squash_mask), 64'(msq));
    chk("R9", "retire_ok", 64'(retire_ok), 64'(er));
  endtask

  task automatic cycle(input string tag, input bit v, input bit ld, input int de,
                       input bit s0v, input int s0, input bit s1v, input int s1,
                       input bit rv, input bit rh, input int rc);
    int col;
    bit fire;
    logic [NC-1:0] nv, cm;
    disp_valid = v; disp_is_load = ld; disp_entry = EW'(de);
    disp_src_vld = {s1v, s0v};
    disp_src_entry = {EW'(s1), EW'(s0)};
    res_valid = rv; res_hit = rh; res_color = CW'(rc);
    #1;
    col = lowest_free(mfree);
    chk("R7", "disp_ready", 64'(disp_ready), 64'(!ld || col >= 0));
    chk("R7", "color_stall", 64'(color_stall), 64'(v && ld && col < 0));
    if (v && ld && col >= 0) chk("R2", "disp_color", 64'(disp_color), 64'(col));
    fire = v && (!ld || col >= 0);
    nv = '0;
    if (s0v) nv |= mv[s0];
    if (s1v) nv |= mv[s1];
    if (fire && ld) nv[col] = 1'b1;
    cm = '0;
    if (rv) cm[rc] = 1'b1;
    for (int e = 0; e < NE; e++) begin
      logic [NC-1:0] seen;
      seen = (fire && e == de) ? nv : mv[e];
      msq[e] = rv && !rh && ((seen & cm) != '0);
      mv[e] = seen & ~cm;
    end
    if (fire && ld) mfree[col] = 1'b0;
    if (rv) mfree[rc] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de));
    for (int e = 0; e < NE; e++) mv[e] = '0;
    mfree = '1;
    msq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check_state("R1");
    chk("R1", "disp_ready", 64'(disp_ready), 64'(1));

    cycle("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);        // e0 load -> color0
    cycle("R4", 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);        // e1 load on e0 -> colors 0,1
    cycle("R3", 1, 0, 2, 1, 1, 0, 0, 0, 0, 0);        // e2 consumer of e1
    cycle("R2", 1, 1, 4, 0, 0, 0, 0, 0, 0, 0);        // e4 load -> color2
    cycle("R3", 1, 0, 3, 1, 2, 0, 4, 0, 0, 0);        // invalid source e4 ignored
    cycle("R2", 1, 1, 5, 0, 0, 0, 0, 0, 0, 0);        // e5 load -> color3, pool empty
    cycle("R7", 1, 1, 6, 1, 4, 0, 0, 0, 0, 0);        // load stalls, no change
    cycle("R7", 1, 0, 6, 1, 4, 0, 0, 0, 0, 0);        // non-load still accepted
    cycle("R8", 1, 0, 7, 1, 3, 0, 0, 1, 0, 1);        // miss color1 + inheriting dispatch
    cycle("R10", 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);       // hit color0
    cycle("R6", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);        // freed color reused
    cycle("R5", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);        // miss on reused color

    for (int i = 0; i < 3000; i++) begin
      bit v, ld, rv, rh;
      int rc;
      v  = ($urandom % 10) < 7;
      ld = ($urandom % 10) < 4;
      rv = 1'b0; rh = 1'b0; rc = 0;
      if (mfree != '1 && ($urandom % 10) < 4) begin
        rv = 1'b1;
        rh = $urandom % 2;
        do rc = $urandom % NC; while (mfree[rc]);
      end
      cycle(rh ? "R6" : "R5", v, ld, $urandom % NE, $urandom % 2, $urandom % NE,
            $urandom % 2, $urandom % NE, rv, rh, rc);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule